// File: doc/BRIEF.md
# DMX512 Frame Receiver with Line-State Closing

This block takes one already-synchronised DMX512 receive line and turns it into byte writes. It watches for a long low period on the line, which marks a BREAK. It then waits for the line to go high again, the mark that follows a BREAK. The first low-going edge after that mark starts the start-code byte. Every later byte is a channel slot.

A selected window of slots is written to a byte-wide port, and each write carries an address relative to the start of the window. A frame closes in one of two ways. Either the requested number of bytes has arrived, or a new BREAK shows up first. A transmitter that sends fewer slots than expected is therefore reported as soon as its next BREAK begins, not after a timeout.

Each closed frame gives one completion pulse. The pulse carries the byte count, the start code and a flag that marks a frame closed early by a BREAK. Bit time and BREAK length are parameters counted in clock cycles. The window start and length come from configuration inputs, which must be held steady while a frame is being received.

Top module: `dmx_frame_rx`

## Requirements
- R1: A BREAK is recognised once `rx` has been sampled low on BRK_CYC consecutive clock cycles. A low run of BRK_CYC-1 cycles is not a BREAK.
- R2: After reset, and while `en` is low, all outputs stay inactive: `wr_en`, `done` and `frame_err` are 0 and `done_bytes` is 0. Until the first BREAK seen with `en` high, bytes on the line cause no write, no completion and no framing error. A BREAK seen while `en` is low produces no completion.
- R3: After a BREAK, reception waits for `rx` to return high. The first low edge after that high period begins byte 0, the start code, whose value is reported on `done_sc`.
- R4: Slots are indexed from 0, where slot 0 is the first byte after the start code. Exactly the slots with index `cfg_start` to `cfg_start+cfg_count-1` are written, each at `wr_addr` equal to its index minus `cfg_start`. No other slot is written.
- R5: The frame completes when the byte count, start code included, reaches `cfg_start+cfg_count+1`. At that point `done` is high for one cycle with `done_short`=0 and `done_bytes` equal to that count. After completion, no further write and no further completion occur until the next BREAK.
- R6: If a BREAK arrives before the target count is reached, `done` pulses with `done_short`=1. `done_bytes` is then the number of bytes received in the frame so far.
- R7: A high period on the line of any length, between slots or after the last slot, neither closes the frame nor stops reception.
- R8: Each BREAK resets the byte count and the window address. The next frame's writes start again at address 0 and its count starts again from 0, however the previous frame ended.
- R9: A byte whose first or second stop bit samples low gives a one-cycle `frame_err` pulse and is not counted or written. The line must then go high before the next byte can start. The leading part of a BREAK that arrives during reception also shows up this way.
- R10: A low pulse on the line that has ended before half a bit time is ignored and starts no byte.
- R11: The target count is capped at 513. With `cfg_start+cfg_count` above 512, a 512-slot frame completes at 513 bytes with `done_short`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Receiver enable; low forces the wait-for-first-BREAK state |
| rx | input | 1 | Synchronised serial line, idle high |
| cfg_start | input | CNT_W | Index of the first slot written |
| cfg_count | input | CNT_W | Number of slots written (1 or more) |
| wr_en | output | 1 | Write strobe for one slot |
| wr_addr | output | CNT_W | Write address relative to the window start |
| wr_data | output | 8 | Slot value |
| done | output | 1 | One-cycle frame completion pulse |
| done_bytes | output | CNT_W | Bytes in the closed frame, start code included |
| done_short | output | 1 | Frame closed by a BREAK before its target count |
| done_sc | output | 8 | Start code of the closed frame |
| frame_err | output | 1 | One-cycle pulse for a dropped byte with a low stop bit |

## Verification
The hardest conditions to reach from the ports are the BREAK-length edges while a frame is still open. A low run one cycle shorter than the threshold must leave the frame running. A run of exactly the threshold must close the frame as short and restart the count.

The bench reaches both by driving `rx` cycle by cycle with directed stimulus. In the middle of an open frame it holds the line low for BRK_CYC-1 clocks, returns it high, sends more slots, and then holds it low for exactly BRK_CYC clocks. Chains of back-to-back short frames, with a requested count larger than the slots sent, show that each BREAK resets the address.

// File: rtl/dmxr_pkg.sv
package dmxr_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP1,
    RX_STOP2,
    RX_WAITHI
  } rx_st_t;

  typedef enum logic [1:0] {
    FR_OFF,
    FR_MAB,
    FR_CAP,
    FR_HOLD
  } fr_st_t;

endpackage

// File: rtl/dmxr_brk_det.sv
module dmxr_brk_det #(
  parameter int BRK_CYC = 8800
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx,
  output logic brk
);
  localparam int BW = $clog2(BRK_CYC + 1);

  logic [BW-1:0] run_q, run_d;

  always_comb begin
    if (rx)                           run_d = '0;
    else if (run_q != BW'(BRK_CYC))   run_d = run_q + 1'b1;
    else                              run_d = run_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  // fires once, on the BRK_CYC-th consecutive low sample
  assign brk = !rx && (run_q == BW'(BRK_CYC - 1));

  AST_BRK_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    brk |=> !brk);  // R1

endmodule

// File: rtl/dmxr_byte_rx.sv
module dmxr_byte_rx
  import dmxr_pkg::*;
#(
  parameter int BIT_CYC = 400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       rx,
  output logic       vld,
  output logic       ferr,
  output logic [7:0] data
);
  localparam int CW   = $clog2(BIT_CYC);
  localparam int HALF = BIT_CYC / 2;

  rx_st_t        st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [2:0]    bit_q, bit_d;
  logic [7:0]    sh_q, sh_d;
  logic          vld_q, vld_d, ferr_q, ferr_d;
  logic          tick;

  assign tick = (cnt_q == CW'(BIT_CYC - 1));

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q + 1'b1;
    bit_d  = bit_q;
    sh_d   = sh_q;
    vld_d  = 1'b0;
    ferr_d = 1'b0;
    case (st_q)
      RX_IDLE: begin
        cnt_d = '0;
        if (!rx) st_d = RX_START;
      end
      RX_START: begin
        if (cnt_q == CW'(HALF - 1)) begin
          cnt_d = '0;
          bit_d = '0;
          st_d  = rx ? RX_IDLE : RX_DATA;
        end
      end
      RX_DATA: begin
        if (tick) begin
          cnt_d = '0;
          sh_d  = {rx, sh_q[7:1]};
          if (bit_q == 3'd7) st_d = RX_STOP1;
          else               bit_d = bit_q + 1'b1;
        end
      end
      RX_STOP1: begin
        if (tick) begin
          cnt_d = '0;
          if (!rx) begin ferr_d = 1'b1; st_d = RX_WAITHI; end
          else     st_d = RX_STOP2;
        end
      end
      RX_STOP2: begin
        if (tick) begin
          cnt_d = '0;
          if (!rx) begin ferr_d = 1'b1; st_d = RX_WAITHI; end
          else     begin vld_d  = 1'b1; st_d = RX_IDLE;   end
        end
      end
      default: begin
        cnt_d = '0;
        if (rx) st_d = RX_IDLE;
      end
    endcase
    if (!run) begin
      st_d   = RX_IDLE;
      cnt_d  = '0;
      vld_d  = 1'b0;
      ferr_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      vld_q  <= 1'b0;
      ferr_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      vld_q  <= vld_d;
      ferr_q <= ferr_d;
    end
  end

  assign vld  = vld_q;
  assign ferr = ferr_q;
  assign data = sh_q;

  AST_VLD_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (vld || ferr) |-> $past(run));  // R2
  AST_VLD_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> $past(rx));  // R9

endmodule

// File: rtl/dmxr_frame_ctl.sv
module dmxr_frame_ctl
  import dmxr_pkg::*;
#(
  parameter int MAX_SLOTS = 512,
  parameter int CNT_W     = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             rx,
  input  logic             brk,
  input  logic             vld,
  input  logic             ferr,
  input  logic [7:0]       data,
  input  logic [CNT_W-1:0] cfg_start,
  input  logic [CNT_W-1:0] cfg_count,
  output logic             run,
  output logic             wr_en,
  output logic [CNT_W-1:0] wr_addr,
  output logic [7:0]       wr_data,
  output logic             done,
  output logic [CNT_W-1:0] done_bytes,
  output logic             done_short,
  output logic [7:0]       done_sc,
  output logic             frame_err
);
  localparam logic [CNT_W:0] LAST = (CNT_W + 1)'(MAX_SLOTS + 1);

  fr_st_t           st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [7:0]       sc_q, sc_d;
  logic             wr_en_d, done_d, short_d, ferr_d;
  logic [CNT_W-1:0] wr_addr_d, bytes_d;
  logic [7:0]       wr_data_d, dsc_d;
  logic [CNT_W:0]   sum, tgt, cnt_inc, win_end;
  logic [CNT_W-1:0] idx, off;
  logic             in_win;

  always_comb begin
    sum     = {1'b0, cfg_start} + {1'b0, cfg_count} + 1'b1;
    tgt     = (sum > LAST) ? LAST : sum;
    win_end = {1'b0, cfg_start} + {1'b0, cfg_count};
    cnt_inc = {1'b0, cnt_q} + 1'b1;
    idx     = cnt_q - 1'b1;
    off     = idx - cfg_start;
    in_win  = (cnt_q != '0) && (idx >= cfg_start) && ({1'b0, idx} < win_end);
  end

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    sc_d      = sc_q;
    wr_en_d   = 1'b0;
    wr_addr_d = wr_addr;
    wr_data_d = wr_data;
    done_d    = 1'b0;
    bytes_d   = done_bytes;
    short_d   = done_short;
    dsc_d     = done_sc;
    ferr_d    = ferr && (st_q == FR_CAP);
    if (!en) begin
      st_d  = FR_OFF;
      cnt_d = '0;
    end else if (brk) begin
      if (st_q == FR_CAP) begin
        done_d  = 1'b1;
        bytes_d = cnt_q;
        short_d = 1'b1;
        dsc_d   = sc_q;
      end
      st_d  = FR_MAB;
      cnt_d = '0;
    end else begin
      case (st_q)
        FR_MAB: if (rx) st_d = FR_CAP;
        FR_CAP: begin
          if (vld) begin
            if (cnt_q == '0) sc_d = data;
            if (in_win) begin
              wr_en_d   = 1'b1;
              wr_addr_d = off;
              wr_data_d = data;
            end
            cnt_d = cnt_inc[CNT_W-1:0];
            if (cnt_inc == tgt) begin
              done_d  = 1'b1;
              bytes_d = cnt_inc[CNT_W-1:0];
              short_d = 1'b0;
              dsc_d   = (cnt_q == '0) ? data : sc_q;
              st_d    = FR_HOLD;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= FR_OFF;
      cnt_q      <= '0;
      sc_q       <= '0;
      wr_en      <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
      done       <= 1'b0;
      done_bytes <= '0;
      done_short <= 1'b0;
      done_sc    <= '0;
      frame_err  <= 1'b0;
    end else begin
      st_q       <= st_d;
      cnt_q      <= cnt_d;
      sc_q       <= sc_d;
      wr_en      <= wr_en_d;
      wr_addr    <= wr_addr_d;
      wr_data    <= wr_data_d;
      done       <= done_d;
      done_bytes <= bytes_d;
      done_short <= short_d;
      done_sc    <= dsc_d;
      frame_err  <= ferr_d;
    end
  end

  assign run = (st_q == FR_CAP);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R5
  AST_WR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr < cfg_count));  // R4
  AST_SHORT_FROM_BRK: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_short) |-> $past(brk));  // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ({1'b0, done_bytes} <= LAST));  // R11

endmodule

// File: rtl/dmx_frame_rx.sv
module dmx_frame_rx #(
  parameter  int BIT_CYC   = 400,
  parameter  int BRK_CYC   = 8800,
  parameter  int MAX_SLOTS = 512,
  localparam int CNT_W     = $clog2(MAX_SLOTS + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             rx,
  input  logic [CNT_W-1:0] cfg_start,
  input  logic [CNT_W-1:0] cfg_count,
  output logic             wr_en,
  output logic [CNT_W-1:0] wr_addr,
  output logic [7:0]       wr_data,
  output logic             done,
  output logic [CNT_W-1:0] done_bytes,
  output logic             done_short,
  output logic [7:0]       done_sc,
  output logic             frame_err
);
  logic       brk, run, vld, ferr;
  logic [7:0] byte_val;

  dmxr_brk_det #(.BRK_CYC(BRK_CYC)) u_brk (
    .clk(clk), .rst_n(rst_n), .rx(rx), .brk(brk)
  );

  dmxr_byte_rx #(.BIT_CYC(BIT_CYC)) u_byte (
    .clk(clk), .rst_n(rst_n), .run(run), .rx(rx),
    .vld(vld), .ferr(ferr), .data(byte_val)
  );

  dmxr_frame_ctl #(.MAX_SLOTS(MAX_SLOTS), .CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .en(en), .rx(rx), .brk(brk),
    .vld(vld), .ferr(ferr), .data(byte_val),
    .cfg_start(cfg_start), .cfg_count(cfg_count),
    .run(run), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .done(done), .done_bytes(done_bytes), .done_short(done_short),
    .done_sc(done_sc), .frame_err(frame_err)
  );

endmodule

// File: tb/sim_dmx_frame_rx.sv
module sim_dmx_frame_rx;
  localparam int BIT = 8;
  localparam int BRK = 176;
  localparam int MAB = 16;
  localparam int CW  = 10;

  logic          clk, rst_n, en, rx;
  logic [CW-1:0] cfg_start, cfg_count;
  logic          wr_en, done, done_short, frame_err;
  logic [CW-1:0] wr_addr, done_bytes;
  logic [7:0]    wr_data, done_sc;

  dmx_frame_rx #(.BIT_CYC(BIT), .BRK_CYC(BRK), .MAX_SLOTS(512)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .rx(rx),
    .cfg_start(cfg_start), .cfg_count(cfg_count),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .done(done), .done_bytes(done_bytes), .done_short(done_short),
    .done_sc(done_sc), .frame_err(frame_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int gen = 0;
  int mem [0:1023];
  int memg [0:1023];
  int wr_cnt = 0, done_cnt = 0, ferr_cnt = 0;
  int last_bytes = 0, last_short = 0, last_sc = 0;
  int d0, w0, f0;
  bit finished = 0;

  always @(negedge clk) begin
    if (wr_en) begin
      mem[wr_addr]  = int'(wr_data);
      memg[wr_addr] = gen;
      wr_cnt++;
    end
    if (done) begin
      done_cnt++;
      last_bytes = int'(done_bytes);
      last_short = int'(done_short);
      last_sc    = int'(done_sc);
    end
    if (frame_err) ferr_cnt++;
  end

  function automatic int pat(int i, int g);
    return (i * 37 + g * 11 + 3) & 255;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic line(bit v, int n);
    rx = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte(logic [7:0] b, bit good = 1'b1);
    line(1'b0, BIT);
    for (int i = 0; i < 8; i++) line(b[i], BIT);
    line(good, BIT);
    line(1'b1, BIT);
  endtask

  task automatic send_break(int n);
    line(1'b0, n);
    line(1'b1, MAB);
  endtask

  task automatic mark();
    gen++;
    d0 = done_cnt;
    w0 = wr_cnt;
    f0 = ferr_cnt;
  endtask

  task automatic send_slots(int first, int n);
    for (int i = first; i < first + n; i++) send_byte(8'(pat(i, gen)));
  endtask

  // n writes at addresses 0..n-1 holding slots base..base+n-1
  task automatic check_data(string tag, int base, int n);
    int bad = 0, act = 0, exp = 0;
    for (int a = 0; a < n; a++) begin
      if (bad == 0 && (memg[a] != gen || mem[a] != pat(base + a, gen))) begin
        bad = 1;
        act = (memg[a] == gen) ? mem[a] : -1;
        exp = pat(base + a, gen);
      end
    end
    check(bad == 0, tag, act, exp);
    check(wr_cnt - w0 == n, tag, wr_cnt - w0, n);
  endtask

  task automatic check_done(string tag, int bytes, int shrt, int sc);
    check(done_cnt - d0 == 1, tag, done_cnt - d0, 1);
    check(last_bytes == bytes, tag, last_bytes, bytes);
    check(last_short == shrt, tag, last_short, shrt);
    if (sc >= 0) check(last_sc == sc, tag, last_sc, sc);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!wr_en && !done && !frame_err, "R2 reset outputs", 1, 0);
    check(done_bytes == '0, "R2 reset done_bytes", int'(done_bytes), 0);
  endtask

  task automatic t_prebreak();
    cfg_start = 0; cfg_count = 4;
    mark();
    send_byte(8'h00);
    send_slots(0, 4);
    line(1'b1, 40);
    check(wr_cnt == w0 && done_cnt == d0 && ferr_cnt == f0,
          "R2 bytes before first break", wr_cnt - w0, 0);
    // enable drop: a break while disabled gives nothing
    send_break(BRK + 20);
    mark();
    send_byte(8'h00);
    send_slots(0, 2);
    en = 1'b0;
    send_break(BRK + 20);
    en = 1'b1;
    send_slots(2, 3);
    line(1'b1, 40);
    check(wr_cnt - w0 == 2 && done_cnt == d0, "R2 en low drops frame",
          wr_cnt - w0, 2);
  endtask

  task automatic t_full();
    cfg_start = 0; cfg_count = 512;
    send_break(BRK + 20);
    mark();
    send_byte(8'h00);
    send_slots(0, 512);
    check_done("R5 full 512-slot frame", 513, 0, 0);
    check_data("R4 full frame data", 0, 512);
  endtask

  task automatic t_window();
    cfg_start = 5; cfg_count = 10;
    send_break(BRK + 20);
    mark();
    send_byte(8'h17);
    send_slots(0, 30);
    check_done("R5 window target", 16, 0, 8'h17);
    check(last_sc == 8'h17, "R3 start code", last_sc, 8'h17);
    check_data("R4 window slots 5..14", 5, 10);
  endtask

  task automatic t_short();
    cfg_start = 0; cfg_count = 200;
    send_break(BRK + 20);
    mark();
    send_byte(8'h00);
    send_slots(0, 192);
    line(1'b1, 3000);
    check(done_cnt == d0, "R7 idle high after last slot", done_cnt - d0, 0);
    send_break(BRK + 20);
    check_done("R6 192-slot frame closed by break", 193, 1, 0);
    check_data("R6 short frame data", 0, 192);
  endtask

  task automatic t_mtbs();
    cfg_start = 0; cfg_count = 4;
    send_break(BRK + 20);
    mark();
    send_byte(8'h00);
    for (int i = 0; i < 4; i++) begin
      line(1'b1, 500);
      send_byte(8'(pat(i, gen)));
    end
    check_done("R7 gaps between slots", 5, 0, 0);
    check_data("R7 gapped data", 0, 4);
  endtask

  task automatic t_b2b();
    int n [3] = '{10, 7, 12};
    cfg_start = 0; cfg_count = 20;
    send_break(BRK + 20);
    for (int k = 0; k < 3; k++) begin
      mark();
      send_byte(8'(k + 1));
      send_slots(0, n[k]);
      send_break(BRK + 20);
      check_done("R8 back-to-back short frame", n[k] + 1, 1, k + 1);
      check_data("R8 address restarts at 0", 0, n[k]);
    end
  endtask

  task automatic t_brkmin();
    cfg_start = 0; cfg_count = 50;
    send_break(BRK + 20);
    mark();
    send_byte(8'h00);
    send_slots(0, 3);
    line(1'b0, BRK - 1);
    line(1'b1, MAB);
    send_slots(3, 2);
    check(done_cnt == d0, "R1 low run of BRK-1 is no break", done_cnt - d0, 0);
    line(1'b0, BRK);
    line(1'b1, MAB);
    check_done("R1 break of exact length closes frame", 6, 1, 0);
    mark();
    send_byte(8'h00);
    send_slots(0, 2);
    send_break(BRK + 20);
    check_done("R1 frame after exact break", 3, 1, 0);
    check_data("R1 frame after exact break data", 0, 2);
  endtask

  task automatic t_ferr();
    cfg_start = 0; cfg_count = 10;
    send_break(BRK + 20);
    mark();
    send_byte(8'h00);
    send_slots(0, 1);
    send_byte(8'hA5, 1'b0);
    line(1'b1, 2 * BIT);
    send_slots(1, 1);
    check(ferr_cnt - f0 == 1, "R9 frame_err pulse", ferr_cnt - f0, 1);
    send_break(BRK + 20);
    check_done("R9 bad byte not counted", 3, 1, 0);
    check_data("R9 next byte at next address", 0, 2);
  endtask

  task automatic t_glitch();
    cfg_start = 0; cfg_count = 3;
    send_break(BRK + 20);
    mark();
    send_byte(8'h00);
    send_slots(0, 1);
    line(1'b0, 2);
    line(1'b1, 20);
    send_slots(1, 2);
    check_done("R10 glitch ignored", 4, 0, 0);
    check_data("R10 data after glitch", 0, 3);
  endtask

  task automatic t_cap();
    cfg_start = 500; cfg_count = 20;
    send_break(BRK + 20);
    mark();
    send_byte(8'h00);
    send_slots(0, 512);
    check_done("R11 target capped at 513", 513, 0, 0);
    check_data("R11 window past end", 500, 12);
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b1; rx = 1'b1;
    cfg_start = '0; cfg_count = 10'd1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_prebreak();
    t_full();
    t_window();
    t_short();
    t_mtbs();
    t_b2b();
    t_brkmin();
    t_ferr();
    t_glitch();
    t_cap();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 195000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule